// File: doc/BRIEF.md
# SCSI Synchronous REQ Strobe Generator

This block drives the target side of a synchronous SCSI data-out transfer. Bytes arrive on a valid/ready stream. Each accepted byte goes onto the data bus. The block then makes one REQ pulse in three timed phases. The first phase lets the data settle with REQ low. The second holds REQ high. The third holds REQ low again until the cycle is complete. All timing is counted in system clock cycles.

Three timing sets are held as configuration inputs, one per transfer mode: Ultra, Fast and SCSI-1. Each set gives:
- a setup field,
- an assertion field,
- a signed trim,
- the smallest sync factor the mode supports at the current clock.

The setup and assertion fields are stored as the cycle count minus one. The negotiated sync factor sets the total cycle length, at 4 ns per unit, rounded up to whole clock cycles. The negation phase is whatever remains of that total, after the trim is added and the setup and assertion phases are taken away.

A request whose sync factor is below the minimum for its mode is refused. The refusal raises a sticky error that stops all strobes until it is cleared.

Top module: `scsi_sync_req_gen`

## Requirements
- R1: After reset, `scsi_req` is low, `scsi_data` is 0 and `err_sync` is low. `s_ready` is high whenever the configuration is acceptable.
- R2: A byte is accepted on a clock edge where `s_valid` and `s_ready` are both high. It appears on `scsi_data` after that edge. `scsi_req` rises exactly setup field + 1 cycles after `scsi_data` changes.
- R3: `scsi_req` stays high for exactly assertion field + 1 cycles.
- R4: The negation phase lasts `ceil(sync*4000 / CLK_PERIOD_PS) + trim - (setup field + 1) - (assertion field + 1)` cycles.
  - It is counted from the fall of `scsi_req` to the next data change when bytes are back to back.
  - `s_ready` is high in the last cycle of this phase.
  - The trim is a two's-complement signed value.
- R5: When the R4 formula gives less than 1, the negation phase lasts exactly 1 cycle.
- R6: `s_ready` is high only when the block is idle, or in the last cycle of the negation phase.
  - It is never high while `scsi_req` is high.
  - `scsi_data` never changes while `scsi_req` is high.
- R7: `cfg_mode` selects the timing set: 0 is Ultra, 1 is Fast and 2 is SCSI-1. The value 3 uses the SCSI-1 set.
- R8: The mode, the sync factor and the fields of the selected set are captured at byte acceptance. Changing them during a cycle does not alter that cycle's setup, assertion or negation lengths.
- R9: If a byte is offered (`s_valid` high) while the block could accept one, and `cfg_sync` is below the selected mode's minimum:
  - `s_ready` stays low;
  - the byte is not taken;
  - `err_sync` goes high on the next edge.
  - A sync factor equal to the minimum is accepted.
- R10: `err_sync` stays high until `err_clr` is high on a clock edge, which clears it. While `err_sync` is high, `s_ready` and `scsi_req` stay low.
- R11: The value on `scsi_data` while `scsi_req` is high is the byte accepted for that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Stream byte available |
| s_data | input | DATA_W | Stream byte |
| s_ready | output | 1 | Block takes the byte on this edge |
| cfg_mode | input | 2 | Timing set select: 0 Ultra, 1 Fast, 2/3 SCSI-1 |
| cfg_sync | input | SYNC_W | Negotiated sync factor (period / 4 ns) |
| cfg_setup | input | 3*FLD_W | Per-mode setup field, cycles minus one |
| cfg_assert | input | 3*FLD_W | Per-mode REQ-high field, cycles minus one |
| cfg_trim | input | 3*TRIM_W | Per-mode signed total-length trim, in cycles |
| cfg_min_sync | input | 3*SYNC_W | Per-mode smallest supported sync factor |
| err_clr | input | 1 | Clears the sticky sync error |
| scsi_data | output | DATA_W | Data bus |
| scsi_req | output | 1 | REQ strobe |
| err_sync | output | 1 | Sticky sync-period rejection flag |

## Verification
Two situations are hard to reach. The first is a configuration change that lands inside a running cycle. The bench changes the mode, sync factor and trims on the negedge straight after a byte is taken. It then times that pulse's three phases, including the negation phase, which is found from the rise of `s_ready`, against the values that held at acceptance. The second is the sticky error while the stream is still pending. The bench offers a byte with a sync factor one below the minimum, then raises the sync factor back to a legal value with the byte still offered. It confirms the bus stays frozen until the clear.

// File: rtl/sreq_pkg.sv
// Shared types and constants for the synchronous REQ strobe generator.
// Assumes exactly three timing sets (Ultra, Fast, SCSI-1).
package sreq_pkg;

    // Number of per-mode timing sets; mode codes at or above this pick the last set.
    localparam int NUM_MODES = 3;

    // Picoseconds represented by one unit of the sync factor.
    localparam int unsigned PS_PER_SYNC_UNIT = 4000;

    // Phase of the REQ cycle.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ASSERT = 2'd2,
        PH_NEGATE = 2'd3
    } phase_e;

endpackage

// File: rtl/sreq_mode_select.sv
// Mode select: picks one of the per-mode timing sets.
// Assumes mode codes 0..NUM_MODES-1 are valid; larger codes fall back to the
// last set (the slowest timing).
module sreq_mode_select
    import sreq_pkg::*;
#(
    parameter int FLD_W  = 4,
    parameter int TRIM_W = 8,
    parameter int SYNC_W = 8
) (
    input  logic [1:0]                        mode,
    input  logic [NUM_MODES-1:0][FLD_W-1:0]   setup_set,
    input  logic [NUM_MODES-1:0][FLD_W-1:0]   assert_set,
    input  logic [NUM_MODES-1:0][TRIM_W-1:0]  trim_set,
    input  logic [NUM_MODES-1:0][SYNC_W-1:0]  min_sync_set,
    output logic [FLD_W-1:0]                  setup_fld,
    output logic [FLD_W-1:0]                  assert_fld,
    output logic signed [TRIM_W-1:0]          trim,
    output logic [SYNC_W-1:0]                 min_sync
);

    localparam logic [1:0] LAST_MODE = 2'(NUM_MODES - 1);

    logic [1:0] idx;

    // Clamp out-of-range mode codes onto the last timing set.
    always_comb begin
        idx = (mode > LAST_MODE) ? LAST_MODE : mode;
    end

    // Multiplex the chosen set's fields.
    always_comb begin
        setup_fld  = '0;
        assert_fld = '0;
        trim       = '0;
        min_sync   = '0;
        for (int m = 0; m < NUM_MODES; m++) begin
            if (idx == 2'(m)) begin
                setup_fld  = setup_set[m];
                assert_fld = assert_set[m];
                trim       = $signed(trim_set[m]);
                min_sync   = min_sync_set[m];
            end
        end
    end

endmodule

// File: rtl/sreq_period_calc.sv
// Period calculator: turns the sync factor into a total cycle count.
// It adds the signed trim, subtracts the setup and assertion phases, and clamps
// the remaining negation length to 1..2**CNT_W-1. It also flags whether the
// sync factor meets the mode's minimum.
// Assumes CLK_PERIOD_PS > 0 and that the products fit in 32 bits.
module sreq_period_calc
    import sreq_pkg::*;
#(
    parameter int SYNC_W        = 8,
    parameter int FLD_W         = 4,
    parameter int TRIM_W        = 8,
    parameter int CNT_W         = 10,
    parameter int CLK_PERIOD_PS = 4000
) (
    input  logic [SYNC_W-1:0]        sync,
    input  logic [SYNC_W-1:0]        min_sync,
    input  logic [FLD_W-1:0]         setup_fld,
    input  logic [FLD_W-1:0]         assert_fld,
    input  logic signed [TRIM_W-1:0] trim,
    output logic [CNT_W-1:0]         neg_len,
    output logic                     sync_ok
);

    localparam int AW = 34;
    localparam logic [31:0] UNIT_PS   = 32'(PS_PER_SYNC_UNIT);
    localparam logic [31:0] PERIOD_W  = 32'(CLK_PERIOD_PS);
    localparam logic [31:0] PERIOD_M1 = 32'(CLK_PERIOD_PS - 1);
    localparam logic signed [AW-1:0] CNT_MAX = (34'sd1 <<< CNT_W) - 34'sd1;

    logic [31:0]          prod_ps;
    logic [31:0]          total_cyc;
    logic signed [AW-1:0] neg_raw;

    // Total cycle length: sync * 4 ns converted to clocks, rounded up.
    always_comb begin
        prod_ps   = 32'(sync) * UNIT_PS;
        total_cyc = (prod_ps + PERIOD_M1) / PERIOD_W;
    end

    // Remainder after trim and the two programmed phases (each field + 1).
    always_comb begin
        neg_raw = $signed({2'b00, total_cyc})
                + AW'(trim)
                - $signed(AW'(setup_fld))
                - $signed(AW'(assert_fld))
                - 34'sd2;
    end

    // Clamp to a legal counter load.
    always_comb begin
        if (neg_raw < 34'sd1) begin
            neg_len = CNT_W'(1);
        end else if (neg_raw > CNT_MAX) begin
            neg_len = '1;
        end else begin
            neg_len = neg_raw[CNT_W-1:0];
        end
    end

    // Rate check against the selected mode's minimum.
    always_comb begin
        sync_ok = (sync >= min_sync);
    end

endmodule

// File: rtl/sreq_phase_seq.sv
// Phase sequencer: takes bytes from the stream and runs the
// setup / assert / negate counter that shapes REQ. It also keeps the sticky
// sync-period error.
// Assumes the period calculator has already clamped neg_len to at least 1.
// Timing is captured at byte acceptance, so later configuration changes
// affect only the next cycle.
module sreq_phase_seq
    import sreq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FLD_W  = 4,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    input  logic              sync_ok,
    input  logic [FLD_W-1:0]  setup_fld,
    input  logic [FLD_W-1:0]  assert_fld,
    input  logic [CNT_W-1:0]  neg_len,
    input  logic              err_clr,
    output logic [DATA_W-1:0] scsi_data,
    output logic              scsi_req,
    output logic              err_sync
);

    phase_e             phase;
    logic [CNT_W-1:0]   cnt;
    logic [FLD_W-1:0]   lat_assert;
    logic [CNT_W-1:0]   lat_neg;
    logic [DATA_W-1:0]  data_q;
    logic               err_q;
    logic               slot_open;
    logic               take;
    logic               reject;
    logic               cnt_zero;

    // A new byte may start in idle or in the final negation cycle.
    always_comb begin
        cnt_zero  = (cnt == '0);
        slot_open = (phase == PH_IDLE) || ((phase == PH_NEGATE) && cnt_zero);
        s_ready   = slot_open && !err_q && sync_ok;
        take      = s_ready && s_valid;
        reject    = slot_open && !err_q && !sync_ok && s_valid;
    end

    // Sticky error: a clear has priority over a new rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end else if (reject) begin
            err_q <= 1'b1;
        end
    end

    // Phase counter and per-cycle timing capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            lat_assert <= '0;
            lat_neg    <= CNT_W'(1);
            data_q     <= '0;
        end else begin
            if (take) begin
                phase      <= PH_SETUP;
                cnt        <= CNT_W'(setup_fld);
                lat_assert <= assert_fld;
                lat_neg    <= neg_len;
                data_q     <= s_data;
            end else begin
                case (phase)
                    PH_SETUP: begin
                        if (cnt_zero) begin
                            phase <= PH_ASSERT;
                            cnt   <= CNT_W'(lat_assert);
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    PH_ASSERT: begin
                        if (cnt_zero) begin
                            phase <= PH_NEGATE;
                            cnt   <= lat_neg - CNT_W'(1);
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    PH_NEGATE: begin
                        if (cnt_zero) begin
                            phase <= PH_IDLE;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    default: begin
                        phase <= PH_IDLE;
                    end
                endcase
            end
        end
    end

    // Drive the bus and strobe from registered state.
    always_comb begin
        scsi_data = data_q;
        scsi_req  = (phase == PH_ASSERT);
        err_sync  = err_q;
    end

endmodule

// File: rtl/scsi_sync_req_gen.sv
// Top level: generates the synchronous-transfer REQ strobe.
// It selects the timing set for the current mode and derives the negation
// length from the sync factor. The sequencer then shapes one REQ pulse for
// each stream byte.
// Assumes all configuration inputs are synchronous to clk.
module scsi_sync_req_gen
    import sreq_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SYNC_W        = 8,
    parameter int FLD_W         = 4,
    parameter int TRIM_W        = 8,
    parameter int CNT_W         = 10,
    parameter int CLK_PERIOD_PS = 4000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              s_valid,
    input  logic [DATA_W-1:0]                 s_data,
    output logic                              s_ready,
    input  logic [1:0]                        cfg_mode,
    input  logic [SYNC_W-1:0]                 cfg_sync,
    input  logic [NUM_MODES-1:0][FLD_W-1:0]   cfg_setup,
    input  logic [NUM_MODES-1:0][FLD_W-1:0]   cfg_assert,
    input  logic [NUM_MODES-1:0][TRIM_W-1:0]  cfg_trim,
    input  logic [NUM_MODES-1:0][SYNC_W-1:0]  cfg_min_sync,
    input  logic                              err_clr,
    output logic [DATA_W-1:0]                 scsi_data,
    output logic                              scsi_req,
    output logic                              err_sync
);

    logic [FLD_W-1:0]         sel_setup;
    logic [FLD_W-1:0]         sel_assert;
    logic signed [TRIM_W-1:0] sel_trim;
    logic [SYNC_W-1:0]        sel_min;
    logic [CNT_W-1:0]         neg_len;
    logic                     sync_ok;

    sreq_mode_select #(
        .FLD_W  (FLD_W),
        .TRIM_W (TRIM_W),
        .SYNC_W (SYNC_W)
    ) u_sel (
        .mode         (cfg_mode),
        .setup_set    (cfg_setup),
        .assert_set   (cfg_assert),
        .trim_set     (cfg_trim),
        .min_sync_set (cfg_min_sync),
        .setup_fld    (sel_setup),
        .assert_fld   (sel_assert),
        .trim         (sel_trim),
        .min_sync     (sel_min)
    );

    sreq_period_calc #(
        .SYNC_W        (SYNC_W),
        .FLD_W         (FLD_W),
        .TRIM_W        (TRIM_W),
        .CNT_W         (CNT_W),
        .CLK_PERIOD_PS (CLK_PERIOD_PS)
    ) u_calc (
        .sync       (cfg_sync),
        .min_sync   (sel_min),
        .setup_fld  (sel_setup),
        .assert_fld (sel_assert),
        .trim       (sel_trim),
        .neg_len    (neg_len),
        .sync_ok    (sync_ok)
    );

    sreq_phase_seq #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .sync_ok    (sync_ok),
        .setup_fld  (sel_setup),
        .assert_fld (sel_assert),
        .neg_len    (neg_len),
        .err_clr    (err_clr),
        .scsi_data  (scsi_data),
        .scsi_req   (scsi_req),
        .err_sync   (err_sync)
    );

endmodule

// File: rtl/sreq_checker.sv
// Port-level protocol checker for scsi_sync_req_gen, attached by bind.
module sreq_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              err_clr,
    input logic [DATA_W-1:0] scsi_data,
    input logic              scsi_req,
    input logic              err_sync
);

    // R6: the bus holds still for the whole REQ-high window.
    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_req |-> $stable(scsi_data));

    // R6: no acceptance while REQ is high.
    p_no_ready_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_req |-> !s_ready);

    // R2: REQ never rises straight out of an acceptance cycle.
    p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scsi_req) |-> !$past(s_ready));

    // R9: the error only rises after a byte was offered and refused.
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sync) |-> ($past(s_valid) && !$past(s_ready)));

    // R10: the error is sticky until cleared.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sync && !err_clr) |=> err_sync);

    // R10: a clear always takes effect.
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !err_sync);

    // R10: a pending error blocks acceptance.
    p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync |-> !s_ready);

endmodule

bind scsi_sync_req_gen sreq_checker #(.DATA_W(DATA_W)) u_sreq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .err_clr   (err_clr),
    .scsi_data (scsi_data),
    .scsi_req  (scsi_req),
    .err_sync  (err_sync)
);

// File: tb/scsi_sync_req_gen_test.sv
module scsi_sync_req_gen_test;
    import sreq_pkg::*;

    localparam int PERIOD_PS = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_valid = 1'b0;
    logic [7:0] s_data = 8'd0;
    logic s_ready;
    logic [1:0] cfg_mode = 2'd0;
    logic [7:0] cfg_sync = 8'd100;
    logic [NUM_MODES-1:0][3:0] cfg_setup;
    logic [NUM_MODES-1:0][3:0] cfg_assert;
    logic [NUM_MODES-1:0][7:0] cfg_trim;
    logic [NUM_MODES-1:0][7:0] cfg_min_sync;
    logic err_clr = 1'b0;
    logic [7:0] scsi_data;
    logic scsi_req;
    logic err_sync;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cur_trim = 0;
    logic [7:0] next_byte = 8'd1;

    int bs_setup[3]  = '{1, 3, 5};
    int bs_assert[3] = '{2, 4, 7};
    int bs_min[3]    = '{12, 25, 50};

    always #10 clk = ~clk;

    scsi_sync_req_gen uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .cfg_mode(cfg_mode), .cfg_sync(cfg_sync),
        .cfg_setup(cfg_setup), .cfg_assert(cfg_assert), .cfg_trim(cfg_trim),
        .cfg_min_sync(cfg_min_sync), .err_clr(err_clr),
        .scsi_data(scsi_data), .scsi_req(scsi_req), .err_sync(err_sync)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int set_idx(input int m);
        return (m > 2) ? 2 : m;
    endfunction

    function automatic int exp_neg(input int m, input int sync, input int trim);
        int k;
        int v;
        k = set_idx(m);
        v = (sync * 4000 + PERIOD_PS - 1) / PERIOD_PS + trim - (bs_setup[k] + 1) - (bs_assert[k] + 1);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic set_cfg(input int m, input int s, input int t);
        cfg_mode = 2'(m);
        cfg_sync = 8'(s);
        cur_trim = t;
        for (int k = 0; k < NUM_MODES; k++) cfg_trim[k] = 8'(t);
    endtask

    // Send n bytes and time every phase of every pulse against the
    // configuration present at the start. Called at a negedge.
    task automatic run_burst(input int n, input bit disturb, input string tneg);
        int k, e_set, e_ass, e_neg, sent, rises, falls, last_d, last_r, last_f, iter;
        bit take, p_req, p_rdy;
        logic [7:0] p_data, base;
        k = set_idx(int'(cfg_mode));
        e_set = bs_setup[k] + 1;
        e_ass = bs_assert[k] + 1;
        e_neg = exp_neg(int'(cfg_mode), int'(cfg_sync), cur_trim);
        base = next_byte;
        sent = 0; rises = 0; falls = 0; last_d = 0; last_r = 0; last_f = 0; iter = 0;
        s_data = base;
        s_valid = 1'b1;
        #1;
        take = s_valid && s_ready;
        p_req = scsi_req; p_rdy = s_ready; p_data = scsi_data;
        while (1) begin
            @(negedge clk);
            iter++;
            if (take) begin
                sent++;
                if (sent == n) s_valid = 1'b0;
                else s_data = base + 8'(sent);
                if (disturb && sent == 1) begin
                    set_cfg((k == 2) ? 0 : 2, 200, 40);
                end
            end
            #1;
            if (scsi_req && !p_req) begin
                rises++;
                check(iter - last_d == e_set, "R2 setup length", iter - last_d, e_set);
                check(scsi_data == base + 8'(rises - 1), "R11 data under REQ",
                      int'(scsi_data), int'(base + 8'(rises - 1)));
                check(!s_ready, "R6 ready low under REQ", int'(s_ready), 0);
                last_r = iter;
            end
            if (!scsi_req && p_req) begin
                falls++;
                check(iter - last_r == e_ass, "R3 REQ width", iter - last_r, e_ass);
                last_f = iter;
            end
            if (scsi_data != p_data) begin
                if (falls > 0) check(iter - last_f == e_neg, tneg, iter - last_f, e_neg);
                check(!scsi_req, "R6 data change under REQ", int'(scsi_req), 0);
                last_d = iter;
            end
            if (s_ready && !p_rdy && falls > 0) begin
                check(iter - last_f == e_neg - 1, tneg, iter - last_f + 1, e_neg);
            end
            take = s_valid && s_ready;
            p_req = scsi_req; p_rdy = s_ready; p_data = scsi_data;
            if (falls == n && s_ready && !scsi_req) break;
            if (iter > 5000) begin
                check(1'b0, "burst timeout", iter, 0);
                break;
            end
        end
        check(rises == n, "R2 pulse count", rises, n);
        next_byte = base + 8'(n);
    endtask

    initial begin
        int syncs[4];
        int trims[3] = '{-6, 0, 9};
        int quiet;
        logic [7:0] held;
        for (int k = 0; k < NUM_MODES; k++) begin
            cfg_setup[k]    = 4'(bs_setup[k]);
            cfg_assert[k]   = 4'(bs_assert[k]);
            cfg_min_sync[k] = 8'(bs_min[k]);
            cfg_trim[k]     = 8'd0;
        end
        set_cfg(0, 100, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(!scsi_req, "R1 req low", int'(scsi_req), 0);
        check(scsi_data == 8'd0, "R1 data zero", int'(scsi_data), 0);
        check(!err_sync, "R1 error low", int'(err_sync), 0);
        check(s_ready, "R1 ready", int'(s_ready), 1);

        // R4, R7: sweep modes (including code 3), sync factors and trims
        for (int m = 0; m < 4; m++) begin
            syncs = '{bs_min[set_idx(m)], bs_min[set_idx(m)] + 7, 90, 255};
            for (int si = 0; si < 4; si++) begin
                for (int ti = 0; ti < 3; ti++) begin
                    set_cfg(m, syncs[si], trims[ti]);
                    run_burst(3, 1'b0, "R4 negation length");
                end
            end
        end

        // R5: clamp to one cycle
        set_cfg(0, 12, -20);
        run_burst(3, 1'b0, "R5 negation clamp");
        set_cfg(2, 50, -128);
        run_burst(2, 1'b0, "R5 negation clamp");

        // R8: configuration disturbed right after acceptance
        set_cfg(0, 40, 3);
        run_burst(1, 1'b1, "R8 latched negation");
        set_cfg(1, 30, 0);
        run_burst(2, 1'b0, "R8 next cycle uses new config");

        // R9: sync below minimum is refused
        held = scsi_data;
        set_cfg(1, 24, 0);
        s_data = next_byte;
        s_valid = 1'b1;
        #1;
        check(!s_ready, "R9 ready low on bad sync", int'(s_ready), 0);
        repeat (2) @(negedge clk);
        #1;
        check(err_sync, "R9 error raised", int'(err_sync), 1);
        quiet = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            #1;
            if (scsi_req || scsi_data != held) quiet++;
        end
        check(quiet == 0, "R9 byte not taken", quiet, 0);

        // R10: sticky even after the sync factor becomes legal
        cfg_sync = 8'd25;
        quiet = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            #1;
            if (scsi_req || s_ready || !err_sync) quiet++;
        end
        check(quiet == 0, "R10 error sticky blocks REQ", quiet, 0);
        s_valid = 1'b0;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        #1;
        check(!err_sync, "R10 error cleared", int'(err_sync), 0);
        check(s_ready, "R10 ready restored", int'(s_ready), 1);

        // R9: sync exactly at the minimum is accepted
        set_cfg(1, 25, 0);
        run_burst(2, 1'b0, "R9 boundary negation");
        set_cfg(2, 49, 0);
        #1;
        check(!s_ready, "R9 one below minimum", int'(s_ready), 0);
        check(!err_sync, "R9 no error without valid", int'(err_sync), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule